// File: doc/BRIEF.md
# Synchronous FIFO with Flop-Driven Read Data

This block is a single-clock first-word-fall-through queue whose read data leaves the block straight from a register. The storage is split in two. An inner queue is built on a memory with a registered read port and holds up to `DEPTH-1` words. A one-word output stage follows it, and the read-port register of the memory acts as that stage. Together they hold exactly `DEPTH` words. `DEPTH` need not be a power of two.

A producer presents `din` with `we`, and the word is taken whenever `writable` is high. A consumer sees the head word on `dout` whenever `readable` is high, and pops it by raising `re`. `level` reports how many words the block holds, counting both the inner queue and the output stage. Because every word passes through the registered memory read, a word written into an empty block appears two cycles after its write. While the output stage is occupied, it is reloaded from the inner queue in the same cycle it is read. A stream of reads therefore sees no gaps.

Top module: `regout_fifo`

## Requirements
- R1: In the first cycle after `rst` is released, `level` is 0, `readable` is low, `writable` is high and `dout` is 0.
- R2: Each cycle, `level` equals its previous value, plus one if the previous cycle had `we` and `writable` both high, minus one if the previous cycle had `re` and `readable` both high.
- R3: `writable` is high exactly when `level` is below `DEPTH`. The block accepts exactly `DEPTH` words. A write offered while `writable` is low is dropped: `level` stays at `DEPTH` and the dropped word never appears on `dout`.
- R4: `readable` is low whenever `level` is 0, and high whenever `level` is greater than 1.
- R5: A word accepted in cycle t by a block whose output stage is empty makes `readable` rise in cycle t+2, with `dout` equal to that word. When `readable` rises, the previous-but-one cycle held an accepted write, and `dout` carries its data.
- R6: A read taken at a level above 1 leaves `readable` high in the next cycle, with the following word on `dout`.
- R7: When `level` was 1 with the word in the output stage, and `level` is still 1 in the next cycle, `readable` in that next cycle is the inverse of the previous `re`.
- R8: If `re` was low in the previous cycle, `dout` is unchanged, except in a cycle where `readable` has just risen.
- R9: Words leave in the order they were accepted, with no loss or duplication.
- R10: Raising `re` while `readable` is low has no effect: `level`, `readable` and `dout` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Write data |
| we | input | 1 | Write request, taken when `writable` is high |
| re | input | 1 | Read request, taken when `readable` is high |
| dout | output | DATA_W | Head word, driven from a register |
| readable | output | 1 | Output stage holds a word |
| writable | output | 1 | Room for at least one more word |
| level | output | $clog2(DEPTH+1) | Words held in total |

## Verification
On every cycle, the embedded properties check these relations:
- the level bookkeeping;
- the bounds between level and `readable`;
- the three cases for `readable` when level is 1: the word stayed, the stage was refilled, or the word arrived two cycles after its write;
- that `dout` holds between reads;
- that the inner queue never overflows.

Only the bench's scenarios against its timestamped queue model can show the other behaviours:
- words come out in order and with the right values over long mixed traffic;
- the block fills to exactly `DEPTH`, a non-power-of-two;
- writes while full and reads while empty are ignored.

// File: rtl/regout_fifo_pkg.sv
package regout_fifo_pkg;

  // Index width for a storage of n words (at least one bit).
  function automatic int unsigned slot_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Width of a counter that must reach n inclusive.
  function automatic int unsigned tally_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/regout_fifo_ram.sv
module regout_fifo_ram
  import regout_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CAP    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              nonempty
);

  localparam int unsigned AW = slot_w(CAP);
  localparam int unsigned CW = tally_w(CAP);
  localparam logic [AW-1:0] LAST = AW'(CAP - 1);

  logic [DATA_W-1:0] store [CAP];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     count;

  // Write port: kept free of reset so the array maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push) store[wptr] <= push_data;
  end

  // Registered read port; this register is the block's output word.
  always_ff @(posedge clk) begin
    if (rst)      rd_data <= '0;
    else if (pop) rd_data <= store[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign nonempty = (count != '0);

  // R3: the outer level limit must keep the inner queue from overflowing
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(CAP)));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));

endmodule

// File: rtl/regout_fifo_outstage.sv
module regout_fifo_outstage (
  input  logic clk,
  input  logic rst,
  input  logic inner_nonempty,
  input  logic take,
  output logic pop,
  output logic valid
);

  // Load the output word when the stage is empty or being drained this cycle.
  assign pop = inner_nonempty && (!valid || take);

  always_ff @(posedge clk) begin
    if (rst)       valid <= 1'b0;
    else if (pop)  valid <= 1'b1;
    else if (take) valid <= 1'b0;
  end

  // R6: a drained stage with words behind it is occupied again next cycle
  p_refill_r6: assert property (@(posedge clk) disable iff (rst)
    (valid && take && inner_nonempty) |=> valid);

endmodule

// File: rtl/regout_fifo.sv
module regout_fifo
  import regout_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DATA_W-1:0]           din,
  input  logic                        we,
  input  logic                        re,
  output logic [DATA_W-1:0]           dout,
  output logic                        readable,
  output logic                        writable,
  output logic [tally_w(DEPTH)-1:0]   level
);

  localparam int unsigned LW    = tally_w(DEPTH);
  localparam int unsigned INNER = DEPTH - 1;

  logic wr_ok, rd_ok, inner_pop, inner_nonempty, stage_valid;
  logic [1:0] age;  // cycles since reset, saturating; used by the properties

  assign writable = (level != LW'(DEPTH));
  assign readable = stage_valid;
  assign wr_ok    = we && writable;
  assign rd_ok    = re && readable;

  regout_fifo_ram #(.DATA_W(DATA_W), .CAP(INNER)) ram_i (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_ok),
    .push_data (din),
    .pop       (inner_pop),
    .rd_data   (dout),
    .nonempty  (inner_nonempty)
  );

  regout_fifo_outstage stage_i (
    .clk            (clk),
    .rst            (rst),
    .inner_nonempty (inner_nonempty),
    .take           (re),
    .pop            (inner_pop),
    .valid          (stage_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= level + LW'(wr_ok) - LW'(rd_ok);
  end

  always_ff @(posedge clk) begin
    if (rst)               age <= '0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (level == '0 && !readable && writable));

  p_level_step_r2: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0) |->
      (int'(level) == int'($past(level)) + int'($past(wr_ok)) - int'($past(rd_ok))));

  p_empty_not_readable_r4: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !readable);

  p_deep_readable_r4: assert property (@(posedge clk) disable iff (rst)
    (level > LW'(1)) |-> readable);

  p_arrival_r5: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && readable && !$past(readable)) |->
      ($past(wr_ok, 2) && dout == $past(din, 2)));

  p_single_from_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && level == LW'(1) && !$past(readable)) |-> (readable == $past(wr_ok, 2)));

  p_refilled_r6: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && level == LW'(1) && $past(readable) && $past(level) > LW'(1)) |-> readable);

  p_sole_word_r7: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && level == LW'(1) && $past(readable) && $past(level) == LW'(1)) |->
      (readable == !$past(re)));

  p_hold_dout_r8: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !$past(re) && !(readable && !$past(readable))) |-> $stable(dout));

endmodule

// File: tb/regout_fifo_tb_top.sv
module regout_fifo_tb_top;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 5;
  localparam int unsigned LW     = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic              we  = 1'b0;
  logic              re  = 1'b0;
  logic [DATA_W-1:0] dout;
  logic              readable, writable;
  logic [LW-1:0]     level;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Reference model: accepted words with the cycle each was written.
  int q_data[$];
  int q_when[$];
  int exp_dout = 0;

  always #2 clk = ~clk;  // 250 MHz

  regout_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .din(din), .we(we), .re(re),
    .dout(dout), .readable(readable), .writable(writable), .level(level)
  );

  function automatic bit m_readable();
    return (q_data.size() > 0) && (cyc >= q_when[0] + 2);
  endfunction

  function automatic bit m_writable();
    return q_data.size() < DEPTH;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    if (m_readable()) exp_dout = q_data[0];
    check(tag, "level", int'(level), q_data.size());
    check(tag, "readable", int'(readable), int'(m_readable()));
    check(tag, "writable", int'(writable), int'(m_writable()));
    check(tag, "dout", int'(dout), exp_dout);
  endtask

  // Compare this cycle's outputs, drive this cycle's inputs, advance one clock.
  task automatic step(input bit w, input int d, input bit r, input string tag);
    bit rd_now, wr_now;
    compare(tag);
    we = w; din = DATA_W'(d); re = r;
    rd_now = m_readable();
    wr_now = m_writable();
    @(posedge clk);
    if (r && rd_now) begin
      void'(q_data.pop_front());
      void'(q_when.pop_front());
    end
    if (w && wr_now) begin
      q_data.push_back(d & 8'hFF);
      q_when.push_back(cyc);
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL all: watchdog expired, got cycle %0d expected completion", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;

    // R1: reset state, then R10: reads into an empty block are ignored
    step(0, 0, 1, "R1");
    step(0, 0, 1, "R10");
    step(0, 0, 1, "R10");
    check("R10", "level after empty reads", int'(level), 0);

    // R5: a single word into an empty block shows up two cycles after its write
    step(1, 8'h3C, 0, "R5");
    check("R5", "readable one cycle after write", int'(readable), 0);
    step(0, 0, 0, "R5");
    check("R5", "readable two cycles after write", int'(readable), 1);
    check("R5", "dout two cycles after write", int'(dout), 8'h3C);
    step(0, 0, 0, "R8");
    step(0, 0, 0, "R8");

    // R7: reading the sole staged word empties the stage
    step(0, 0, 1, "R7");
    check("R7", "readable after sole read", int'(readable), 0);
    check("R7", "dout holds after sole read", int'(dout), 8'h3C);
    step(0, 0, 0, "R7");

    // R3: fill to exactly DEPTH, extra writes dropped
    for (int i = 0; i < DEPTH + 2; i++) step(1, 8'h10 + i, 0, "R3");
    check("R3", "level when full", int'(level), DEPTH);
    check("R3", "writable when full", int'(writable), 0);
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R8");

    // R6 and R9: drain back to back, each read refills the stage
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, (i < DEPTH - 1) ? "R6" : "R9");
    check("R6", "readable after full drain", int'(readable), 0);
    check("R9", "last drained word", int'(dout), 8'h10 + DEPTH - 1);
    step(0, 0, 0, "R4");

    // R2: simultaneous read and write at steady level
    step(1, 8'hA1, 0, "R2");
    step(1, 8'hA2, 0, "R2");
    step(0, 0, 0, "R2");
    for (int i = 0; i < 6; i++) step(1, 8'hB0 + i, 1, "R2");
    check("R2", "level under balanced traffic", int'(level), 2);
    for (int i = 0; i < 3; i++) step(0, 0, 1, "R9");

    // R7: write into an empty block while reading the sole word
    step(1, 8'hC1, 0, "R7");
    step(0, 0, 0, "R7");
    step(1, 8'hC2, 1, "R7");
    check("R7", "readable after read with concurrent write", int'(readable), 0);
    step(0, 0, 0, "R5");
    check("R5", "second word arrives", int'(dout), 8'hC2);
    step(0, 0, 1, "R9");

    // R8 and R9: mixed random traffic
    for (int i = 0; i < 2000; i++)
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
           1'($urandom_range(0, 2) != 0), "R9");
    for (int i = 0; i < DEPTH + 3; i++) step(0, 0, 1, "R8");
    check("R9", "level after final drain", int'(level), 0);

    summary();
    $finish;
  end

endmodule